// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter with a parallel preset. Its width is a parameter and defaults to four bits, which gives a modulo-16 counter that wraps from 15 to 0. The counter advances only when two enables are both high. The first, `cnt_en`, gates counting alone. The second, `chain_en`, gates counting and also qualifies the combinational carry-out `chain_out`. When the active-low `load_n` is low at a rising clock edge, the count takes the value on `data_in`. The enables have no effect on a load.

To build a wider counter, place several instances side by side on one clock. Feed each stage's `chain_out` into the next stage's `chain_en`, and share `cnt_en` across all stages. The carry then needs no extra gates, and every stage changes on the same clock edge.

The parameter `ASYNC_RESET` selects how the active-low reset works. With `ASYNC_RESET = 1`, the reset clears the count at once, whatever the clock, load or enables are doing. With the default `ASYNC_RESET = 0`, the reset is sampled on the rising edge and takes priority over load and count.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_n` is low, `count_q` reads 0 after the next rising edge, in both reset styles.
- R2: With `rst_n` high and `load_n` low at a rising edge, `count_q` equals the `data_in` sampled at that edge.
- R3: With `rst_n` high, `load_n` high, and both `cnt_en` and `chain_en` high at a rising edge, `count_q` increases by one, modulo 2^WIDTH.
- R4: With `rst_n` high, `load_n` high, and either enable low at a rising edge, `count_q` keeps its value.
- R5: `chain_out` is 1 exactly when `count_q` is all ones (15 at the default width) and `chain_en` is 1. It follows `chain_en` within the same clock cycle.
- R6: When the counter advances from the all-ones value, it becomes 0.
- R7: A load takes effect whatever the levels of `cnt_en` and `chain_en`.
- R8: With `ASYNC_RESET = 1`, a falling `rst_n` drives `count_q` to 0 before any clock edge.
- R9: With `ASYNC_RESET = 0`, `count_q` does not change when `rst_n` falls between clock edges. A low `rst_n` at the edge overrides a simultaneous load or count and gives 0.
- R10: Two stages, with the low stage's `chain_out` driving the high stage's `chain_en` and `cnt_en` shared, count as one 2×WIDTH-bit counter through all 256 values and wrap. The high stage's `chain_out` is 1 only at count 255 with the first stage's `chain_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous, set by `ASYNC_RESET` |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable; gates counting only |
| chain_en | input | 1 | Carry-in enable; gates counting and `chain_out` |
| data_in | input | WIDTH | Parallel preset value |
| count_q | output | WIDTH | Current count |
| chain_out | output | 1 | Carry-out: count is all ones and `chain_en` is high |

## Verification
The bench builds two 8-bit chains of two default-width stages each. One chain uses `ASYNC_RESET = 0` and the other uses `ASYNC_RESET = 1`, and both receive the same stimulus. Running them side by side shows both reset styles on the same cycles: the asynchronous chain clears in the middle of a cycle while the synchronous chain holds until the edge. Chaining the stages brings the carry path between them within reach, including the 15-to-0 carry into the high stage and the full 255-to-0 wrap of the pair.

// File: rtl/pbc_pkg.sv
`timescale 1ns/1ps
// Package: types shared by the presettable counter modules.
// Assumes: none.
package pbc_pkg;
    // What the state register does at the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } pbc_action_e;
endpackage

// File: rtl/pbc_ctrl.sv
`timescale 1ns/1ps
// Module: pbc_ctrl
// Resolves the control inputs into one action per edge.
// Priority: synchronous clear, then load, then count, then hold.
// Assumes: in the asynchronous style the register handles reset itself,
// so this module never picks a clear.
module pbc_ctrl
    import pbc_pkg::*;
#(
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic        rst_n,
    input  logic        load_n,
    input  logic        cnt_en,
    input  logic        chain_en,
    output pbc_action_e action
);
    localparam bit USE_SYNC_CLEAR = !ASYNC_RESET;

    // Pick the highest-priority action that is requested.
    always_comb begin
        if (USE_SYNC_CLEAR && !rst_n)
            action = ACT_CLEAR;
        else if (!load_n)
            action = ACT_LOAD;
        else if (cnt_en && chain_en)
            action = ACT_COUNT;
        else
            action = ACT_HOLD;
    end
endmodule

// File: rtl/pbc_state_reg.sv
`timescale 1ns/1ps
// Module: pbc_state_reg
// Count register. The reset style is chosen at elaboration time.
// Assumes: the action comes from pbc_ctrl and is stable before the edge.
module pbc_state_reg
    import pbc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pbc_action_e      action,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    // Next value for each action.
    always_comb begin
        case (action)
            ACT_CLEAR: q_next = ZERO;
            ACT_LOAD:  q_next = load_val;
            ACT_COUNT: q_next = q + ONE;
            default:   q_next = q;
        endcase
    end

    generate
        if (ASYNC_RESET) begin : g_async
            // Flop with an immediate clear.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= ZERO;
                else        q <= q_next;
            end
        end else begin : g_sync
            // Flop; the clear arrives through the action.
            always_ff @(posedge clk) begin
                q <= q_next;
            end
        end
    endgenerate

    // R2: a load takes the preset value.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_LOAD |=> q == $past(load_val));

    // R3: a count adds one.
    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_COUNT |=> q == WIDTH'($past(q) + ONE));

    // R4: a hold keeps the value.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        action == ACT_HOLD |=> $stable(q));
endmodule

// File: rtl/pbc_term.sv
`timescale 1ns/1ps
// Module: pbc_term
// Combinational carry-out used to cascade stages.
// Assumes: none; there is no register on this path.
module pbc_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             chain_out
);
    // High on the last count, qualified by the carry-in enable.
    always_comb chain_out = chain_en && (&q);
endmodule

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
// Module: presettable_counter
// Cascadable presettable up-counter with split count enables.
// Assumes: all stages of a chain share one clock; ASYNC_RESET selects
// the reset style.
module presettable_counter
    import pbc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count_q,
    output logic             chain_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    pbc_action_e action;

    pbc_ctrl #(.ASYNC_RESET(ASYNC_RESET)) u_ctrl (
        .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .action(action)
    );

    pbc_state_reg #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_reg (
        .clk(clk), .rst_n(rst_n), .action(action),
        .load_val(data_in), .q(count_q)
    );

    pbc_term #(.WIDTH(WIDTH)) u_term (
        .q(count_q), .chain_en(chain_en), .chain_out(chain_out)
    );

    // R5: the carry-out is set on the last count with chain_en high.
    p_carry_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == ALL_ONES && chain_en) |-> chain_out);

    // R5: the carry-out is never set off the last count.
    p_carry_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out |-> (count_q == ALL_ONES));

    // R6: advancing from all ones wraps to zero.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == ALL_ONES && load_n && cnt_en && chain_en) |=> count_q == '0);

    // R7: a load ignores both enables.
    p_load_any_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !(cnt_en && chain_en)) |=> count_q == $past(data_in));
endmodule

// File: tb/presettable_counter_bench.sv
`timescale 1ns/1ps
module presettable_counter_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, ld_n, en_p, en_t;
    logic [7:0] din;
    logic [3:0] s_lo, s_hi, a_lo, a_hi;
    logic       s_tc_lo, s_tc_hi, a_tc_lo, a_tc_hi;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model = 8'd0;

    // Synchronous-reset chain.
    presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_presettable_counter (
        .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_p), .chain_en(en_t),
        .data_in(din[3:0]), .count_q(s_lo), .chain_out(s_tc_lo));
    presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_presettable_counter_hi (
        .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_p), .chain_en(s_tc_lo),
        .data_in(din[7:4]), .count_q(s_hi), .chain_out(s_tc_hi));
    // Asynchronous-reset chain.
    presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_async_lo (
        .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_p), .chain_en(en_t),
        .data_in(din[3:0]), .count_q(a_lo), .chain_out(a_tc_lo));
    presettable_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_async_hi (
        .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_p), .chain_en(a_tc_lo),
        .data_in(din[7:4]), .count_q(a_hi), .chain_out(a_tc_hi));

    // Reference next value for the 8-bit chain.
    function automatic logic [7:0] ref_next(logic [7:0] cur, logic r, logic l,
                                            logic p, logic t, logic [7:0] d);
        if (!r)          return 8'd0;
        else if (!l)     return d;
        else if (p && t) return cur + 8'd1;
        else             return cur;
    endfunction

    function automatic logic ref_tc(logic [7:0] cur, logic t);
        return t && (cur == 8'hFF);
    endfunction

    task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive at the falling edge, update the model at the rising edge, and
    // compare both chains 1 ns after the edge.
    task automatic step(string tag, logic r, logic l, logic p, logic t, logic [7:0] d);
        @(negedge clk);
        rst_n = r; ld_n = l; en_p = p; en_t = t; din = d;
        @(posedge clk);
        model = ref_next(model, r, l, p, t, d);
        #1;
        check(tag, {s_tc_hi, s_hi, s_lo}, {ref_tc(model, en_t), model});
        check(tag, {a_tc_hi, a_hi, a_lo}, {ref_tc(model, en_t), model});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        rst_n = 1'b0; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = 8'd0;
        // R1: reset state.
        step("R1", 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        step("R1", 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A);
        // R10: full walk through 0..255 and the wrap back to 0.
        for (int i = 0; i < 257; i++) step("R10", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        // R2 and R7: loads with the enables low.
        step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 8'hA7);
        step("R2", 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C);
        // R4: hold with either enable low.
        step("R4", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        step("R4", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        step("R3", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        // R5: the carry-out follows chain_en within the cycle.
        step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
        @(negedge clk); ld_n = 1'b1; en_p = 1'b0; en_t = 1'b1; #1;
        check("R5", {s_tc_hi, a_tc_hi, s_tc_lo}, 9'b111);
        en_t = 1'b0; #1;
        check("R5", {s_tc_hi, a_tc_hi, s_tc_lo}, 9'b000);
        // R6: wrap from all ones.
        step("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        // R8 and R9: reset falling between edges.
        step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h9E);
        @(negedge clk); rst_n = 1'b0; ld_n = 1'b0; en_p = 1'b1; en_t = 1'b1; din = 8'h44; #1;
        check("R8", {1'b0, a_hi, a_lo}, 9'h000);
        check("R9", {1'b0, s_hi, s_lo}, 9'h09E);
        @(posedge clk); model = 8'd0; #1;
        check("R9", {1'b0, s_hi, s_lo}, 9'h000);
        // R3: random mix of all controls.
        for (int i = 0; i < 3000; i++) begin
            logic r, l, p, t;
            r = ($urandom % 20) != 0;
            l = ($urandom % 8) != 0;
            p = ($urandom % 4) != 0;
            t = ($urandom % 4) != 0;
            step("R3", r, l, p, t, 8'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule